// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog peripheral reached over a 32-bit APB-style register bus. Once enabled, a single counter first times an interrupt stage. When that stage expires, a sticky status flag is set and an interrupt is raised. The same counter then times a reset stage. When the reset stage expires and reset is enabled, the block emits a one-clock system reset pulse. Both stage lengths are powers of two, chosen by small index fields. The counter advances either on every bus clock or on each rising edge of a slow external clock, which is brought into the bus domain through a two-flop synchronizer.

Software services the watchdog by writing a key to the restart register, which sends the counter back to the start of the interrupt stage. Writes to the control and restart registers are accepted only right after an unlock key has been written. The parameter `INT_W` (3 or 4) sets how many bits of the interrupt index are writable. It also sets the counter width (16 or 32 bits). Software can probe the supported range by writing all ones to the field and reading it back.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `sys_rst` are low.
- R2: Register byte offsets are 0x10 control, 0x14 restart, 0x18 unlock and 0x1C status. The control fields are: bit 0 enable, bit 1 clock select, bit 3 reset enable, bits 7:4 interrupt index, bits 10:8 reset index. Bit 2 and bits 31:11 read 0.
- R3: Writing 0x5AA5 to offset 0x18 opens exactly the next bus write. A control or restart write that arrives while the block is locked is ignored. Any write other than the unlock key locks the block again.
- R4: Only the low `INT_W` bits of the interrupt index are writable. Writing all ones reads back 2^INT_W-1.
- R5: Status bit 1 becomes set 2^n counter ticks after the counter starts, where n is taken by the interrupt index from {6,8,10,11,12,13,14,15,17,19,21,23,25,27,29,31}.
- R6: `irq` is high exactly while status bit 1 is set and enable is 1.
- R7: Writing 1 to status bit 1 clears it, and writing 0 there has no effect. If the clear and an interrupt-stage expiry fall in the same cycle, the bit ends up set.
- R8: The reset stage starts only when the interrupt stage expires and lasts 2^(7+index) ticks. On its expiry, `sys_rst` pulses for one clock if reset enable is 1, and stays low if it is 0. The interrupt stage then begins again.
- R9: An unlocked write of 0xCAFE to offset 0x14 clears the counter and returns it to the interrupt stage. Any other value written there has no effect.
- R10: When clock select is 1, the counter ticks every clock. When it is 0, the counter ticks once per rising edge of `ext_clk` and does not advance while `ext_clk` is idle.
- R11: While enable is 0, the counter is held at zero and no stage can expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Slow external timing clock |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | ADDR_W | Bus byte address |
| pwdata | input | 32 | Bus write data |
| prdata | output | 32 | Bus read data |
| irq | output | 1 | Interrupt, level |
| sys_rst | output | 1 | System reset pulse |

## Verification
The status flag has two drivers that can act in the same clock: the interrupt-stage expiry that sets it, and the software write-one-to-clear. The bench enables a 64-tick interrupt stage on the bus clock. It then times a status clear so that the clear's access edge lands on the exact edge where the stage expires. It reads the flag afterwards and expects it to be set, and it expects exactly one rising `irq` at that edge. Restart writes that are locked or carry a wrong key are placed inside a running interrupt stage. Any one of them that were wrongly accepted would move the expected interrupt cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0]  OFF_CTRL    = 8'h10;
    localparam logic [7:0]  OFF_RESTART = 8'h14;
    localparam logic [7:0]  OFF_UNLOCK  = 8'h18;
    localparam logic [7:0]  OFF_STATUS  = 8'h1C;
    localparam logic [31:0] KEY_UNLOCK  = 32'h0000_5AA5;
    localparam logic [31:0] KEY_RESTART = 32'h0000_CAFE;

    typedef enum logic {
        ST_INT = 1'b0,
        ST_RST = 1'b1
    } stage_e;

    typedef struct packed {
        logic [2:0] rst_idx;
        logic [3:0] int_idx;
        logic       rst_en;
        logic       clk_sel;
        logic       en;
    } ctrl_t;

    // exponent of the interrupt-stage period selected by an index
    function automatic logic [4:0] int_exp(input logic [3:0] idx);
        logic [4:0] e;
        if (idx == 4'd0)      e = 5'd6;
        else if (idx == 4'd1) e = 5'd8;
        else if (idx < 4'd8)  e = 5'({1'b0, idx}) + 5'd8;
        else                  e = {idx, 1'b1};
        return e;
    endfunction

    // exponent of the reset-stage period selected by an index
    function automatic logic [4:0] rst_exp(input logic [2:0] idx);
        return 5'({2'b00, idx}) + 5'd7;
    endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic ext_clk,
    output logic tick
);
    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] shreg;
    } sync_t;

    sync_t sync_q, sync_d;
    logic  ext_rise;

    always_comb begin
        sync_d       = sync_q;
        sync_d.shreg = {sync_q.shreg[SW-2:0], ext_clk};
        ext_rise     = sync_q.shreg[SW-2] & ~sync_q.shreg[SW-1];
        tick         = clk_sel ? 1'b1 : ext_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // ext-sourced ticks come from single edges, never back to back
    p_ext_sparse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_sel && ext_rise) |=> !ext_rise);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       restart,
    input  logic       rst_en,
    input  logic [3:0] int_idx,
    input  logic [2:0] rst_idx,
    output logic       int_expire,
    output logic       rst_pulse
);
    localparam logic [CNT_W-1:0] ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        stage_e           stage;
        logic             pulse;
    } tstate_t;

    tstate_t          q, d;
    logic [4:0]       cur_exp;
    logic [5:0]       shamt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        cur_exp    = (q.stage == ST_INT) ? int_exp(int_idx) : rst_exp(rst_idx);
        shamt      = 6'(CNT_W) - {1'b0, cur_exp};
        limit      = ONES >> shamt;
        d          = q;
        d.pulse    = 1'b0;
        int_expire = 1'b0;
        if (!en || restart) begin
            d.cnt   = '0;
            d.stage = ST_INT;
        end else if (tick) begin
            if (q.cnt == limit) begin
                d.cnt = '0;
                if (q.stage == ST_INT) begin
                    int_expire = 1'b1;
                    d.stage    = ST_RST;
                end else begin
                    d.stage = ST_INT;
                    d.pulse = rst_en;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rst_pulse = q.pulse;

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.cnt == '0 && q.stage == ST_INT));
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |=> !q.pulse);
    p_pulse_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |-> $past(rst_en));
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && en) |=> (q.cnt == '0 && q.stage == ST_INT));

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int INT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic              int_expire,
    output logic [31:0]       prdata,
    output ctrl_t             ctrl,
    output logic              restart,
    output logic              int_flag
);
    localparam logic [3:0] INT_MASK = 4'((1 << INT_W) - 1);

    typedef struct packed {
        ctrl_t ctrl;
        logic  unlock;
        logic  flag;
    } rstate_t;

    rstate_t q, d;
    logic    wr;
    logic    hit_ctrl, hit_restart, hit_unlock, hit_status;

    always_comb begin
        wr          = psel & penable & pwrite;
        hit_ctrl    = (paddr == ADDR_W'(OFF_CTRL));
        hit_restart = (paddr == ADDR_W'(OFF_RESTART));
        hit_unlock  = (paddr == ADDR_W'(OFF_UNLOCK));
        hit_status  = (paddr == ADDR_W'(OFF_STATUS));
        d           = q;
        restart     = wr & hit_restart & q.unlock & (pwdata == KEY_RESTART);
        if (wr) begin
            d.unlock = hit_unlock & (pwdata == KEY_UNLOCK);
            if (hit_ctrl && q.unlock) begin
                d.ctrl.en      = pwdata[0];
                d.ctrl.clk_sel = pwdata[1];
                d.ctrl.rst_en  = pwdata[3];
                d.ctrl.int_idx = pwdata[7:4] & INT_MASK;
                d.ctrl.rst_idx = pwdata[10:8];
            end
            if (hit_status && pwdata[1]) d.flag = 1'b0;
        end
        if (int_expire) d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        prdata = '0;
        if (hit_ctrl)
            prdata = {21'd0, q.ctrl.rst_idx, q.ctrl.int_idx, q.ctrl.rst_en,
                      1'b0, q.ctrl.clk_sel, q.ctrl.en};
        else if (hit_status)
            prdata = {30'd0, q.flag, 1'b0};
    end

    assign ctrl     = q.ctrl;
    assign int_flag = q.flag;

    p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ctrl && !q.unlock) |=> $stable(q.ctrl));
    p_unlock_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(hit_unlock && pwdata == KEY_UNLOCK)) |=> !q.unlock);
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_expire |=> q.flag);
    p_int_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl.int_idx & ~INT_MASK) == 4'd0);

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int INT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              irq,
    output logic              sys_rst
);
    localparam int CNT_W = (INT_W >= 4) ? 32 : 16;

    ctrl_t ctrl;
    logic  restart, int_flag, int_expire, tick;

    wdog_regs #(.ADDR_W(ADDR_W), .INT_W(INT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .int_expire(int_expire), .prdata(prdata), .ctrl(ctrl),
        .restart(restart), .int_flag(int_flag)
    );

    wdog_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .clk_sel(ctrl.clk_sel),
        .ext_clk(ext_clk), .tick(tick)
    );

    wdog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.en),
        .restart(restart), .rst_en(ctrl.rst_en), .int_idx(ctrl.int_idx),
        .rst_idx(ctrl.rst_idx), .int_expire(int_expire), .rst_pulse(sys_rst)
    );

    assign irq = int_flag & ctrl.en;

    p_reset_follows_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> $past(ctrl.en));

endmodule

// File: tb/wdog_twostage_test.sv
module wdog_twostage_test;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W      = 4;

    typedef struct {
        int     kind;
        longint at;
        int     tol;
        string  req;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq, sys_rst;
    logic [1:0]  ext_div = '0;
    logic        ext_run = 1'b0;
    logic        ext_clk;
    logic        irq_prev = 1'b0;
    longint      cyc = 0;
    int          checks = 0, fails = 0, rst_seen = 0;
    ev_t         exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (ext_run) ext_div <= ext_div + 2'd1;
    assign ext_clk = ext_div[1];

    wdog_twostage uut (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq(irq), .sys_rst(sys_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    task automatic observe(input int kind);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R8/R5: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || cyc < e.at - e.tol || cyc > e.at + e.tol) begin
                fails++;
                $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // monitor: compares events as they appear against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !irq_prev) observe(1);
            if (sys_rst) begin rst_seen++; observe(2); end
            irq_prev = irq;
        end
    end

    task automatic expect_ev(input int kind, input longint at, input int tol, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.tol = tol; e.req = req;
        exp_q.push_back(e);
    endtask

    // all bus tasks start and end at a falling edge; access edge = start cycle + 2
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = v;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1; v = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_to(input longint t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic unlocked_wr(input logic [7:0] a, input logic [31:0] v);
        bus_wr(8'h18, 32'h5AA5);
        bus_wr(a, v);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        longint w, x, s;
        int rs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 sys_rst", {31'd0, sys_rst}, 32'd0);
        bus_rd(8'h10, rd); check("R1 ctrl", rd, 32'd0);
        bus_rd(8'h1C, rd); check("R1 status", rd, 32'd0);

        // R3 locked control write ignored
        bus_wr(8'h10, 32'h0000_000B);
        bus_rd(8'h10, rd); check("R3 locked ctrl", rd, 32'd0);

        // R2 / R4 field layout and writable interrupt width
        unlocked_wr(8'h10, 32'hFFFF_FFFF);
        bus_rd(8'h10, rd);
        check("R2 R4 readback", rd, 32'h0000_070B | (((32'd1 << INT_W) - 1) << 4));
        bus_wr(8'h10, 32'h0);
        bus_rd(8'h10, rd); check("R3 single use", rd[3:0], 4'hB);
        bus_wr(8'h18, 32'h5AA5);
        bus_wr(8'h1C, 32'h0);
        bus_wr(8'h10, 32'h0);
        bus_rd(8'h10, rd); check("R3 other write relocks", rd[3:0], 4'hB);
        unlocked_wr(8'h10, 32'h0);
        bus_rd(8'h10, rd); check("R3 unlocked ctrl", rd, 32'd0);

        // R5 / R8 interrupt then reset stage on the bus clock
        unlocked_wr(8'h10, 32'h0000_000B);
        w = cyc;
        expect_ev(1, w + 64, 0, "R5");
        expect_ev(2, w + 192, 0, "R8");
        expect_ev(1, w + 256, 0, "R8 restart of int stage");
        wait_to(w + 100);
        bus_rd(8'h1C, rd); check("R5 status", rd, 32'd2);
        check("R6 irq level", {31'd0, irq}, 32'd1);
        wait_to(w + 196);
        bus_wr(8'h1C, 32'd2);
        wait_to(w + 262);
        bus_rd(8'h1C, rd); check("R8 int stage again", rd, 32'd2);
        unlocked_wr(8'h10, 32'h0);
        check("R6 irq off when disabled", {31'd0, irq}, 32'd0);
        bus_wr(8'h1C, 32'd0);
        bus_rd(8'h1C, rd); check("R7 write 0 no effect", rd, 32'd2);
        bus_wr(8'h1C, 32'd2);
        bus_rd(8'h1C, rd); check("R7 w1c", rd, 32'd0);
        s = cyc; wait_to(s + 600);
        bus_rd(8'h1C, rd); check("R11 idle no expiry", rd, 32'd0);

        // R9 restart, locked and wrong-key restarts ignored, reset disabled
        unlocked_wr(8'h10, 32'h0000_0013);
        w = cyc;
        wait_to(w + 150);
        unlocked_wr(8'h14, 32'h0000_CAFE);
        x = cyc;
        expect_ev(1, x + 256, 0, "R9");
        rs0 = rst_seen;
        wait_to(x + 100);
        bus_wr(8'h14, 32'h0000_CAFE);
        wait_to(x + 150);
        unlocked_wr(8'h14, 32'h0000_1234);
        wait_to(x + 200);
        bus_rd(8'h1C, rd); check("R9 not yet expired", rd, 32'd0);
        wait_to(x + 420);
        bus_rd(8'h1C, rd); check("R9 expired", rd, 32'd2);
        check("R8 no pulse without enable", rst_seen, rs0);
        unlocked_wr(8'h10, 32'h0);
        bus_wr(8'h1C, 32'd2);

        // R7 clear and expiry in the same cycle: set wins
        unlocked_wr(8'h10, 32'h0000_0003);
        w = cyc;
        expect_ev(1, w + 64, 0, "R7");
        wait_to(w + 62);
        bus_wr(8'h1C, 32'd2);
        bus_rd(8'h1C, rd); check("R7 set wins", rd, 32'd2);
        unlocked_wr(8'h10, 32'h0);
        bus_wr(8'h1C, 32'd2);

        // R10 external clock source
        unlocked_wr(8'h10, 32'h0000_0001);
        w = cyc;
        wait_to(w + 300);
        bus_rd(8'h1C, rd); check("R10 idle ext clock", rd, 32'd0);
        s = cyc;
        expect_ev(1, s + 258, 8, "R10");
        ext_run = 1'b1;
        wait_to(s + 300);
        bus_rd(8'h1C, rd); check("R10 ext expiry", rd, 32'd2);
        ext_run = 1'b0;
        unlocked_wr(8'h10, 32'h0);
        bus_wr(8'h1C, 32'd2);

        repeat (4) @(negedge clk);
        check("R5 all events seen", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule